// File: doc/BRIEF.md
# Column Command Spacing and Burst Overlap Checker

This block decides, one candidate at a time, whether a proposed memory column command (a read or a write, with or without auto-precharge) may be issued at a given cycle. It keeps a small history of the column commands that were actually issued. For each entry it stores the issue cycle, the full bank index, the command type and the data-bus window that command occupies. A candidate is rejected when it is the same type as a recorded command and either their data-bus burst windows intersect or their issue cycles are too close for the column-to-column spacing rule. The spacing is a long value inside one bank group and a short value across groups.

A scheduler presents the candidate with its bank and absolute issue cycle. It sets the commit input when a legal candidate is really issued, so that the candidate enters the history. The verdict appears one cycle later. Entries whose window ended more than a configured horizon before the current candidate's issue cycle are dropped so that their slots can be reused. When a committed command finds no free slot, a sticky error is raised. All timing values are counted in clock cycles.

Top module: `ccc_timing_checker`

## Requirements
- R1: After reset `res_valid`, `res_legal` and `ovf_err` are 0 and the history is empty, so the first candidate is always legal.
- R2: `res_valid` is 1 in exactly the cycle after `cand_valid` was 1, and `res_legal` carries the verdict for that candidate. `res_legal` is 0 whenever `res_valid` is 0.
- R3: A read at cycle t occupies the data bus over [t+`cfg_rl`, t+`cfg_rl`+L), where L = `cfg_burst_len` >> `DR_LOG2` (L must be at least 1). A read whose window intersects a recorded read's window is illegal. Windows that only touch at a boundary are legal.
- R4: A write uses the same rule with `cfg_wl` in place of `cfg_rl`, checked against recorded writes.
- R5: Two same-type commands in the same bank group (equal upper `BG_W` bits of the bank index) are illegal when |t1 - t2| < `cfg_ccd_l`, whichever of them is earlier. A distance of exactly `cfg_ccd_l` is legal.
- R6: Two same-type commands in different bank groups are illegal when |t1 - t2| < `cfg_ccd_s`.
- R7: A read is never rejected because of a recorded write, and a write is never rejected because of a recorded read.
- R8: Only a candidate that has both `cand_commit`=1 and a legal verdict is recorded. An uncommitted or illegal candidate leaves the history unchanged.
- R9: When a candidate with issue cycle t is presented, every entry whose window end e satisfies e < t and t - e > `cfg_horizon` is removed. Its slot is then free for that same candidate.
- R10: A committed legal candidate that finds all `DEPTH` slots occupied after pruning is not recorded, and it sets `ovf_err`. `ovf_err` stays 1 until reset.
- R11: `cand_autopre` has no effect on the verdict or on recording: auto-precharge variants are treated exactly like plain reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | A candidate is presented this cycle |
| cand_write | input | 1 | 1 = write, 0 = read |
| cand_autopre | input | 1 | Auto-precharge variant |
| cand_bank | input | BANK_W | Bank index; the upper BG_W bits are the bank group |
| cand_time | input | TIME_W | Absolute issue cycle of the candidate |
| cand_commit | input | 1 | Record the candidate if it is legal |
| cfg_rl | input | LAT_W | Read latency in cycles |
| cfg_wl | input | LAT_W | Write latency in cycles |
| cfg_burst_len | input | BL_W | Burst length in beats |
| cfg_ccd_l | input | LAT_W | Same-group column spacing |
| cfg_ccd_s | input | LAT_W | Cross-group column spacing |
| cfg_horizon | input | TIME_W | History retention after a window ends |
| res_valid | output | 1 | Verdict valid |
| res_legal | output | 1 | Candidate may issue |
| ovf_err | output | 1 | Sticky history overflow |

## Verification
The assertions take the configuration as static while candidates are present. They assume that the burst length shifted by the data rate is never zero, and that issue cycles stay far enough from the top of the `TIME_W` range that window arithmetic cannot wrap. The bench changes configuration only between resets, uses burst lengths of 4 and 16 with a double data rate, and keeps every issue cycle below a few hundred. It places candidates on both sides of recorded commands, exactly at and one cycle inside each spacing and window boundary.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

    typedef enum logic [1:0] {
        CMD_RD  = 2'b00,
        CMD_RDA = 2'b01,
        CMD_WR  = 2'b10,
        CMD_WRA = 2'b11
    } col_cmd_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } chk_state_e;

    function automatic logic cmd_is_write(input col_cmd_e c);
        return (c == CMD_WR) || (c == CMD_WRA);
    endfunction

endpackage

// File: rtl/ccc_window.sv
module ccc_window #(
    parameter int TIME_W  = 16,
    parameter int LAT_W   = 6,
    parameter int BL_W    = 5,
    parameter int DR_LOG2 = 1
) (
    input  logic              is_write,
    input  logic [TIME_W-1:0] issue_t,
    input  logic [LAT_W-1:0]  rl,
    input  logic [LAT_W-1:0]  wl,
    input  logic [BL_W-1:0]   burst_len,
    output logic [TIME_W-1:0] win_start,
    output logic [TIME_W-1:0] win_end
);
    localparam int PAD_LAT = TIME_W - LAT_W;
    localparam int PAD_BL  = TIME_W - BL_W;

    logic [LAT_W-1:0]  lat;
    logic [BL_W-1:0]   beats_clk;

    always_comb begin
        lat       = is_write ? wl : rl;
        beats_clk = burst_len >> DR_LOG2;
        win_start = issue_t + {{PAD_LAT{1'b0}}, lat};
        win_end   = win_start + {{PAD_BL{1'b0}}, beats_clk};
    end
endmodule

// File: rtl/ccc_slot_cmp.sv
module ccc_slot_cmp #(
    parameter int TIME_W = 16,
    parameter int LAT_W  = 6,
    parameter int BANK_W = 4,
    parameter int BG_W   = 2
) (
    input  logic              e_live,
    input  logic              e_wr,
    input  logic [BANK_W-1:0] e_bank,
    input  logic [TIME_W-1:0] e_t,
    input  logic [TIME_W-1:0] e_ws,
    input  logic [TIME_W-1:0] e_we,
    input  logic              c_wr,
    input  logic [BANK_W-1:0] c_bank,
    input  logic [TIME_W-1:0] c_t,
    input  logic [TIME_W-1:0] c_ws,
    input  logic [TIME_W-1:0] c_we,
    input  logic [LAT_W-1:0]  ccd_l,
    input  logic [LAT_W-1:0]  ccd_s,
    output logic              conflict
);
    localparam int LO_W    = BANK_W - BG_W;
    localparam int PAD_LAT = TIME_W - LAT_W;

    logic [BANK_W-1:0] bank_diff;
    logic              same_grp;
    logic              same_kind;
    logic [TIME_W-1:0] gap;
    logic [LAT_W-1:0]  spacing;
    logic              too_close;
    logic              overlap;

    always_comb begin
        bank_diff = (e_bank ^ c_bank) >> LO_W;
        same_grp  = (bank_diff == '0);
        same_kind = (e_wr == c_wr);
        gap       = (c_t >= e_t) ? (c_t - e_t) : (e_t - c_t);
        spacing   = same_grp ? ccd_l : ccd_s;
        too_close = gap < {{PAD_LAT{1'b0}}, spacing};
        overlap   = (c_ws < e_we) && (e_ws < c_we);
        conflict  = e_live && same_kind && (overlap || too_close);
    end
endmodule

// File: rtl/ccc_history.sv
module ccc_history #(
    parameter int TIME_W = 16,
    parameter int BANK_W = 4,
    parameter int DEPTH  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          upd,
    input  logic                          ins,
    input  logic [TIME_W-1:0]             now_t,
    input  logic [TIME_W-1:0]             horizon,
    input  logic                          in_wr,
    input  logic [BANK_W-1:0]             in_bank,
    input  logic [TIME_W-1:0]             in_ws,
    input  logic [TIME_W-1:0]             in_we,
    output logic [DEPTH-1:0]              live,
    output logic [DEPTH-1:0]              vld,
    output logic [DEPTH-1:0]              wr,
    output logic [DEPTH-1:0][BANK_W-1:0]  bank,
    output logic [DEPTH-1:0][TIME_W-1:0]  t,
    output logic [DEPTH-1:0][TIME_W-1:0]  ws,
    output logic [DEPTH-1:0][TIME_W-1:0]  we,
    output logic                          no_room
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] expired;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;
    logic [TIME_W-1:0] in_t;

    assign in_t = now_t;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_prune
            assign expired[g] = (we[g] < now_t) && ((now_t - we[g]) > horizon);
            assign live[g]    = vld[g] && !expired[g];
        end
    endgenerate

    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!live[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
        no_room = !free_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= '0;
            wr   <= '0;
            bank <= '0;
            t    <= '0;
            ws   <= '0;
            we   <= '0;
        end else if (upd) begin
            vld <= live;
            if (ins && free_any) begin
                vld[free_idx]  <= 1'b1;
                wr[free_idx]   <= in_wr;
                bank[free_idx] <= in_bank;
                t[free_idx]    <= in_t;
                ws[free_idx]   <= in_ws;
                we[free_idx]   <= in_we;
            end
        end
    end
endmodule

// File: rtl/ccc_timing_checker.sv
module ccc_timing_checker #(
    parameter int TIME_W  = 16,
    parameter int LAT_W   = 6,
    parameter int BL_W    = 5,
    parameter int DR_LOG2 = 1,
    parameter int BANK_W  = 4,
    parameter int BG_W    = 2,
    parameter int DEPTH   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic              cand_write,
    input  logic              cand_autopre,
    input  logic [BANK_W-1:0] cand_bank,
    input  logic [TIME_W-1:0] cand_time,
    input  logic              cand_commit,
    input  logic [LAT_W-1:0]  cfg_rl,
    input  logic [LAT_W-1:0]  cfg_wl,
    input  logic [BL_W-1:0]   cfg_burst_len,
    input  logic [LAT_W-1:0]  cfg_ccd_l,
    input  logic [LAT_W-1:0]  cfg_ccd_s,
    input  logic [TIME_W-1:0] cfg_horizon,
    output logic              res_valid,
    output logic              res_legal,
    output logic              ovf_err
);
    import ccc_pkg::*;

    col_cmd_e          cmd;
    logic              c_wr;
    logic [TIME_W-1:0] c_ws;
    logic [TIME_W-1:0] c_we;

    logic [DEPTH-1:0]             hist_live;
    logic [DEPTH-1:0]             hist_vld;
    logic [DEPTH-1:0]             hist_wr;
    logic [DEPTH-1:0][BANK_W-1:0] hist_bank;
    logic [DEPTH-1:0][TIME_W-1:0] hist_t;
    logic [DEPTH-1:0][TIME_W-1:0] hist_ws;
    logic [DEPTH-1:0][TIME_W-1:0] hist_we;
    logic                         hist_full;
    logic [DEPTH-1:0]             slot_hit;
    logic                         legal_now;
    logic                         record;

    chk_state_e state_q, state_d;
    logic       legal_q;
    logic       ovf_q;

    assign cmd  = col_cmd_e'({cand_write, cand_autopre});
    assign c_wr = cmd_is_write(cmd);

    ccc_window #(
        .TIME_W (TIME_W),
        .LAT_W  (LAT_W),
        .BL_W   (BL_W),
        .DR_LOG2(DR_LOG2)
    ) u_win (
        .is_write (c_wr),
        .issue_t  (cand_time),
        .rl       (cfg_rl),
        .wl       (cfg_wl),
        .burst_len(cfg_burst_len),
        .win_start(c_ws),
        .win_end  (c_we)
    );

    ccc_history #(
        .TIME_W(TIME_W),
        .BANK_W(BANK_W),
        .DEPTH (DEPTH)
    ) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (cand_valid),
        .ins    (record),
        .now_t  (cand_time),
        .horizon(cfg_horizon),
        .in_wr  (c_wr),
        .in_bank(cand_bank),
        .in_ws  (c_ws),
        .in_we  (c_we),
        .live   (hist_live),
        .vld    (hist_vld),
        .wr     (hist_wr),
        .bank   (hist_bank),
        .t      (hist_t),
        .ws     (hist_ws),
        .we     (hist_we),
        .no_room(hist_full)
    );

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            ccc_slot_cmp #(
                .TIME_W(TIME_W),
                .LAT_W (LAT_W),
                .BANK_W(BANK_W),
                .BG_W  (BG_W)
            ) u_cmp (
                .e_live  (hist_live[g]),
                .e_wr    (hist_wr[g]),
                .e_bank  (hist_bank[g]),
                .e_t     (hist_t[g]),
                .e_ws    (hist_ws[g]),
                .e_we    (hist_we[g]),
                .c_wr    (c_wr),
                .c_bank  (cand_bank),
                .c_t     (cand_time),
                .c_ws    (c_ws),
                .c_we    (c_we),
                .ccd_l   (cfg_ccd_l),
                .ccd_s   (cfg_ccd_s),
                .conflict(slot_hit[g])
            );
        end
    endgenerate

    assign legal_now = (slot_hit == '0);
    assign record    = cand_valid && cand_commit && legal_now;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   state_d = cand_valid ? S_REPORT : S_IDLE;
            S_REPORT: state_d = cand_valid ? S_REPORT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register with verdict and sticky overflow capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            legal_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            legal_q <= cand_valid && legal_now;
            if (record && hist_full) begin
                ovf_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_IDLE: begin
                res_valid = 1'b0;
                res_legal = 1'b0;
            end
            S_REPORT: begin
                res_valid = 1'b1;
                res_legal = legal_q;
            end
            default: begin
                res_valid = 1'b0;
                res_legal = 1'b0;
            end
        endcase
        ovf_err = ovf_q;
    end
endmodule

// File: rtl/ccc_timing_checker_sva.sv
module ccc_timing_checker_sva #(
    parameter int BL_W    = 5,
    parameter int DR_LOG2 = 1,
    parameter int DEPTH   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cand_valid,
    input logic             cand_commit,
    input logic [BL_W-1:0]  cfg_burst_len,
    input logic             res_valid,
    input logic             res_legal,
    input logic             ovf_err,
    input logic [DEPTH-1:0] hist_vld
);
    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |=> res_valid);

    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_valid |=> !res_valid);

    assert_legal_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_legal);

    assert_burst_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> ((cfg_burst_len >> DR_LOG2) != '0));

    assert_hist_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_valid |=> $stable(hist_vld));

    assert_hist_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_commit |=> $countones(hist_vld) <= $past($countones(hist_vld)));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    assert_ovf_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_err) |-> $past(cand_valid && cand_commit));
endmodule

bind ccc_timing_checker ccc_timing_checker_sva #(
    .BL_W   (BL_W),
    .DR_LOG2(DR_LOG2),
    .DEPTH  (DEPTH)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .cand_valid   (cand_valid),
    .cand_commit  (cand_commit),
    .cfg_burst_len(cfg_burst_len),
    .res_valid    (res_valid),
    .res_legal    (res_legal),
    .ovf_err      (ovf_err),
    .hist_vld     (hist_vld)
);

// File: tb/ccc_timing_checker_bench.sv
module ccc_timing_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cand_valid = 1'b0;
    logic        cand_write = 1'b0;
    logic        cand_autopre = 1'b0;
    logic [3:0]  cand_bank = '0;
    logic [15:0] cand_time = '0;
    logic        cand_commit = 1'b0;
    logic [5:0]  cfg_rl = 6'd10;
    logic [5:0]  cfg_wl = 6'd8;
    logic [4:0]  cfg_burst_len = 5'd16;
    logic [5:0]  cfg_ccd_l = 6'd6;
    logic [5:0]  cfg_ccd_s = 6'd4;
    logic [15:0] cfg_horizon = 16'd20;
    logic        res_valid, res_legal, ovf_err;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    exp_q[$];
    string tag_q[$];
    bit    finished = 1'b0;

    always #5 clk = ~clk;

    ccc_timing_checker u_ccc_timing_checker (
        .clk(clk), .rst_n(rst_n),
        .cand_valid(cand_valid), .cand_write(cand_write),
        .cand_autopre(cand_autopre), .cand_bank(cand_bank),
        .cand_time(cand_time), .cand_commit(cand_commit),
        .cfg_rl(cfg_rl), .cfg_wl(cfg_wl), .cfg_burst_len(cfg_burst_len),
        .cfg_ccd_l(cfg_ccd_l), .cfg_ccd_s(cfg_ccd_s), .cfg_horizon(cfg_horizon),
        .res_valid(res_valid), .res_legal(res_legal), .ovf_err(ovf_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected verdicts as results appear
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected result", 1, 0);
            end else begin
                check(tag_q.pop_front(), int'(res_legal), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic do_reset(input int bl, input int hz);
        cand_valid    = 1'b0;
        cand_commit   = 1'b0;
        rst_n         = 1'b0;
        cfg_burst_len = 5'(bl);
        cfg_horizon   = 16'(hz);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic present(input bit wr, input bit ap, input int bank, input int t,
                           input bit commit, input bit exp, input string tag);
        cand_valid   = 1'b1;
        cand_write   = wr;
        cand_autopre = ap;
        cand_bank    = 4'(bank);
        cand_time    = 16'(t);
        cand_commit  = commit;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle();
        cand_valid  = 1'b0;
        cand_commit = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        // R1 reset state
        do_reset(16, 20);
        check("R1 res_valid", int'(res_valid), 0);
        check("R1 res_legal", int'(res_legal), 0);
        check("R1 ovf_err", int'(ovf_err), 0);

        // R3 read window overlap, len 8, RL 10
        present(0, 0, 0, 100, 1, 1, "R1 first candidate legal");
        present(0, 0, 4, 106, 0, 0, "R3 overlap cross group");
        present(0, 0, 4, 108, 0, 1, "R3 touching end legal");
        present(0, 0, 0, 107, 0, 0, "R3 overlap same group");
        present(0, 0, 4, 93, 0, 0, "R3 overlap earlier");
        present(0, 0, 4, 92, 0, 1, "R3 touching start legal");
        idle();
        check("R2 no result when idle", int'(res_valid), 0);

        // R5 / R6 spacing, len 2
        do_reset(4, 20);
        present(0, 0, 0, 100, 1, 1, "R5 seed");
        present(0, 0, 1, 105, 0, 0, "R5 same group too close after");
        present(0, 0, 1, 106, 0, 1, "R5 same group exact spacing");
        present(0, 0, 0, 95, 0, 0, "R5 same group too close before");
        present(0, 0, 0, 94, 0, 1, "R5 same group exact before");
        present(0, 0, 8, 103, 0, 0, "R6 cross group too close");
        present(0, 0, 8, 104, 0, 1, "R6 cross group exact");
        present(0, 0, 8, 97, 0, 0, "R6 cross group close before");
        present(0, 0, 8, 96, 0, 1, "R6 cross group exact before");
        idle();

        // R4 write window with WL, R7 cross-type independence
        do_reset(16, 20);
        present(1, 0, 0, 100, 1, 1, "R4 seed write");
        present(1, 0, 4, 106, 0, 0, "R4 write overlap");
        present(1, 0, 4, 108, 0, 1, "R4 write touching legal");
        present(0, 0, 0, 101, 0, 1, "R7 read near write");
        present(0, 0, 0, 100, 0, 1, "R7 read same cycle as write");
        idle();

        // R11 auto-precharge variants
        do_reset(16, 20);
        present(1, 1, 0, 100, 1, 1, "R11 seed write-ap");
        present(1, 1, 4, 106, 0, 0, "R11 write-ap overlap");
        present(1, 1, 4, 108, 1, 1, "R11 write-ap recorded");
        present(1, 0, 4, 110, 0, 0, "R11 plain write vs write-ap");
        idle();

        // R8 recording only when committed and legal
        do_reset(4, 20);
        present(0, 0, 0, 100, 0, 1, "R8 uncommitted");
        present(0, 0, 0, 101, 1, 1, "R8 uncommitted not recorded");
        present(0, 0, 0, 103, 1, 0, "R8 illegal commit");
        present(0, 0, 0, 107, 0, 1, "R8 illegal not recorded");
        idle();

        // R10 overflow with large horizon
        do_reset(4, 200);
        for (int i = 0; i < 8; i++) present(0, 0, 0, i * 10, 1, 1, "R10 fill");
        idle();
        check("R10 no overflow at full", int'(ovf_err), 0);
        present(0, 0, 0, 80, 1, 1, "R10 ninth legal");
        check("R10 overflow raised", int'(ovf_err), 1);
        present(0, 0, 0, 85, 0, 1, "R10 ninth not recorded");
        present(0, 0, 0, 200, 0, 1, "R10 later candidate");
        idle();
        check("R10 overflow sticky", int'(ovf_err), 1);

        // R9 pruning frees slots
        do_reset(4, 20);
        for (int i = 0; i < 8; i++) present(0, 0, 0, i * 10, 1, 1, "R9 fill");
        present(0, 0, 0, 80, 1, 1, "R9 commit after prune");
        idle();
        check("R9 no overflow", int'(ovf_err), 0);
        present(0, 0, 0, 85, 0, 0, "R9 pruned slot reused");
        idle();
        idle();

        if (exp_q.size() != 0) check("R2 missing results", exp_q.size(), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule